// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Process Tags

This block caches recent virtual-to-physical page translations for a processor's load/store path. Each lookup supplies a virtual page number, the page offset, the identifier of the running process and a read/write flag. In the same cycle, all stored translations are compared against the request. The block then reports exactly one outcome. A hit returns the physical address. A miss means no valid entry belongs to this process and page. A fault means a write reached a page that is mapped read-only.

Every entry carries a process tag. Because of this, translations from different processes can live side by side and a context switch needs no flush. A hit also marks the entry as referenced. A write hit to a page whose modified flag is still clear raises a request so that software can update its page table.

A software miss handler installs entries through a refill port at an index it chooses. It can remove one entry by index, or clear the whole buffer in one cycle.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid, so every lookup with `lk_valid_i` high reports a miss.
- R2: After an entry is refilled, a lookup with the same page number and process tag hits in the following cycle, combinationally. The physical address is `{pfn, lk_off_i}`, and `lk_idx_o` gives the entry index.
- R3: An entry whose process tag differs from `lk_asid_i` never matches.
- R4: An entry refilled with `fill_rw_i`=0 is read-only. A write lookup (`lk_write_i`=1) that matches it raises `lk_fault_o`, with `lk_hit_o` low and `lk_pa_o` zero, while a read lookup hits.
- R5: `lk_ref_o` shows the referenced flag of the matched entry. A refill clears this flag, and a hit (but not a fault) sets it at the next clock edge.
- R6: A write hit on an entry whose modified flag (`fill_dirty_i` at refill) is 0 raises `lk_dirty_req_o`. A read hit, or a write hit on an already modified entry, does not.
- R7: `inv_en_i` clears the entry at `inv_idx_i` at the next edge, and leaves all other entries intact.
- R8: `inv_all_i` clears every entry at the next edge. It takes priority over a refill in the same cycle.
- R9: When several valid entries match, the lowest index supplies the result.
- R10: With `lk_valid_i` low, all outcome outputs, `lk_pa_o`, `lk_idx_o` and `lk_ref_o` are 0. With it high, exactly one of hit, miss and fault is set.
- R11: A refill replaces the entry at its index, so the translation previously held there no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | 20 | Virtual page number |
| lk_off_i | input | 12 | Page offset |
| lk_asid_i | input | 6 | Current process tag |
| lk_write_i | input | 1 | 1 = write access, 0 = read |
| lk_hit_o | output | 1 | Translation valid |
| lk_miss_o | output | 1 | No matching entry |
| lk_fault_o | output | 1 | Write to read-only page |
| lk_dirty_req_o | output | 1 | Write hit on unmodified page |
| lk_pa_o | output | 32 | Physical address on hit, else 0 |
| lk_idx_o | output | 6 | Matched index on hit or fault, else 0 |
| lk_ref_o | output | 1 | Referenced flag of matched entry, else 0 |
| fill_en_i | input | 1 | Refill strobe |
| fill_idx_i | input | 6 | Refill index |
| fill_vpn_i | input | 20 | Refill page number |
| fill_pfn_i | input | 20 | Refill frame number |
| fill_asid_i | input | 6 | Refill process tag |
| fill_rw_i | input | 1 | 1 = read/write, 0 = read-only |
| fill_dirty_i | input | 1 | Initial modified flag |
| inv_en_i | input | 1 | Single-entry invalidate strobe |
| inv_idx_i | input | 6 | Index to invalidate |
| inv_all_i | input | 1 | Invalidate every entry |

## Verification
A corrupted valid flag, tag or frame field becomes visible on the very next lookup of that page. It shows up as a wrong outcome, a wrong frame in `lk_pa_o` or a wrong `lk_idx_o`, in the same cycle as the lookup. A referenced flag that is lost or set too early appears through `lk_ref_o` on the second lookup to the entry. A wrong priority among duplicate matches appears as a wrong index as soon as two entries share a page. The bench keeps a model of all entries and compares every output on every cycle. This includes stretches where refills, invalidations and lookups touch the same index back to back.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VPN_W  = 20;
  localparam int unsigned PFN_W  = 20;
  localparam int unsigned ASID_W = 6;
  localparam int unsigned OFF_W  = 12;

  typedef struct packed {
    logic              valid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [ASID_W-1:0] asid;
    logic              rw;
    logic              dirty;
    logic              refd;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_we_i,
  input  tlb_entry_t        fill_i,
  input  logic              inv_i,
  input  logic              touch_i,
  input  logic [VPN_W-1:0]  q_vpn_i,
  input  logic [ASID_W-1:0] q_asid_i,
  output logic              match_o,
  output tlb_entry_t        entry_o
);
  tlb_entry_t e_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        e_q <= '0;
    else if (inv_i)     e_q.valid <= 1'b0;
    else if (fill_we_i) e_q <= fill_i;
    else if (touch_i)   e_q.refd <= 1'b1;
  end

  assign match_o = e_q.valid && (e_q.vpn == q_vpn_i) && (e_q.asid == q_asid_i);
  assign entry_o = e_q;

  assert_inv_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_i |=> !entry_o.valid);
  assert_fill_clears_ref_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_we_i && !inv_i) |=> (entry_o.valid && !entry_o.refd));
endmodule

// File: rtl/tlb_lowest_sel.sv
module tlb_lowest_sel #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     match_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     sel_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (match_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    sel_o = '0;
    if (found_o) sel_o[idx_o] = 1'b1;
  end

  assert_sel_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o));
  assert_sel_in_match_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o & ~match_i) == '0);
  assert_lowest_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> ((match_i & (sel_o - 1'b1)) == '0));
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENT = 64,
  localparam int unsigned IDX_W = $clog2(N_ENT),
  localparam int unsigned PA_W  = PFN_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [OFF_W-1:0]  lk_off_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              lk_write_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic              lk_fault_o,
  output logic              lk_dirty_req_o,
  output logic [PA_W-1:0]   lk_pa_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  output logic              lk_ref_o,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic              fill_rw_i,
  input  logic              fill_dirty_i,
  input  logic              inv_en_i,
  input  logic [IDX_W-1:0]  inv_idx_i,
  input  logic              inv_all_i
);
  tlb_entry_t              fill_ent;
  tlb_entry_t [N_ENT-1:0]  ents;
  logic       [N_ENT-1:0]  match;
  logic       [N_ENT-1:0]  sel;
  logic                    found;
  logic       [IDX_W-1:0]  idx;
  tlb_entry_t              e_sel;
  logic                    any_match, fault, hit;

  always_comb begin
    fill_ent       = '0;
    fill_ent.valid = 1'b1;
    fill_ent.vpn   = fill_vpn_i;
    fill_ent.pfn   = fill_pfn_i;
    fill_ent.asid  = fill_asid_i;
    fill_ent.rw    = fill_rw_i;
    fill_ent.dirty = fill_dirty_i;
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    tlb_entry u_ent (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .fill_we_i(fill_en_i && (fill_idx_i == IDX_W'(g))),
      .fill_i   (fill_ent),
      .inv_i    (inv_all_i || (inv_en_i && (inv_idx_i == IDX_W'(g)))),
      .touch_i  (hit && sel[g]),
      .q_vpn_i  (lk_vpn_i),
      .q_asid_i (lk_asid_i),
      .match_o  (match[g]),
      .entry_o  (ents[g])
    );
  end

  tlb_lowest_sel #(.N(N_ENT), .IDX_W(IDX_W)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .match_i(match),
    .found_o(found),
    .idx_o  (idx),
    .sel_o  (sel)
  );

  assign e_sel     = ents[idx];
  assign any_match = lk_valid_i && found;
  assign fault     = any_match && lk_write_i && !e_sel.rw;
  assign hit       = any_match && !fault;

  assign lk_hit_o       = hit;
  assign lk_fault_o     = fault;
  assign lk_miss_o      = lk_valid_i && !found;
  assign lk_dirty_req_o = hit && lk_write_i && !e_sel.dirty;
  assign lk_pa_o        = hit ? {e_sel.pfn, lk_off_i} : '0;
  assign lk_idx_o       = any_match ? idx : '0;
  assign lk_ref_o       = any_match ? e_sel.refd : 1'b0;

  assert_one_outcome_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |-> ($countones({lk_hit_o, lk_miss_o, lk_fault_o}) == 1));
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> !(lk_hit_o || lk_miss_o || lk_fault_o || lk_dirty_req_o || lk_ref_o));
  assert_dirty_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_dirty_req_o |-> (lk_hit_o && lk_write_i));
  assert_fault_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> (lk_write_i && lk_pa_o == '0));
  assert_inv_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> !(lk_hit_o || lk_fault_o));
  assert_ref_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && !inv_all_i && !inv_en_i && !fill_en_i) |=> ($past(e_sel.refd) || ents[$past(idx)].refd));
endmodule

// File: tb/tb_tlb_fa.sv
module tb_tlb_fa;
  import tlb_pkg::*;
  localparam int N = 64;
  localparam int IW = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic              lk_valid = 0, lk_write = 0;
  logic [VPN_W-1:0]  lk_vpn = '0;
  logic [OFF_W-1:0]  lk_off = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic              hit, miss, fault, dreq, refo;
  logic [PFN_W+OFF_W-1:0] pa;
  logic [IW-1:0]     idxo;
  logic              fill_en = 0, fill_rw = 0, fill_dirty = 0;
  logic [IW-1:0]     fill_idx = '0, inv_idx = '0;
  logic [VPN_W-1:0]  fill_vpn = '0;
  logic [PFN_W-1:0]  fill_pfn = '0;
  logic [ASID_W-1:0] fill_asid = '0;
  logic              inv_en = 0, inv_all = 0;

  tlb_fa dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid), .lk_vpn_i(lk_vpn), .lk_off_i(lk_off),
    .lk_asid_i(lk_asid), .lk_write_i(lk_write),
    .lk_hit_o(hit), .lk_miss_o(miss), .lk_fault_o(fault),
    .lk_dirty_req_o(dreq), .lk_pa_o(pa), .lk_idx_o(idxo), .lk_ref_o(refo),
    .fill_en_i(fill_en), .fill_idx_i(fill_idx), .fill_vpn_i(fill_vpn),
    .fill_pfn_i(fill_pfn), .fill_asid_i(fill_asid), .fill_rw_i(fill_rw),
    .fill_dirty_i(fill_dirty), .inv_en_i(inv_en), .inv_idx_i(inv_idx),
    .inv_all_i(inv_all)
  );

  logic              m_v [N];
  logic [VPN_W-1:0]  m_vpn [N];
  logic [PFN_W-1:0]  m_pfn [N];
  logic [ASID_W-1:0] m_asid [N];
  logic              m_rw [N], m_d [N], m_r [N];

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic tick(input string tag);
    logic [42:0] exp_v, act_v;
    int  hi;
    bit  fnd, e_hit, e_fault;
    #1;
    fnd = 0; hi = 0;
    for (int i = N-1; i >= 0; i--)
      if (m_v[i] && m_vpn[i] == lk_vpn && m_asid[i] == lk_asid) begin fnd = 1; hi = i; end
    e_fault = lk_valid && fnd && lk_write && !m_rw[hi];
    e_hit   = lk_valid && fnd && !e_fault;
    exp_v = {e_hit, lk_valid && !fnd, e_fault, e_hit && lk_write && !m_d[hi],
             e_hit ? {m_pfn[hi], lk_off} : 32'd0,
             (lk_valid && fnd) ? IW'(hi) : IW'(0),
             (lk_valid && fnd) ? m_r[hi] : 1'b0};
    act_v = {hit, miss, fault, dreq, pa, idxo, refo};
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act_v, exp_v);
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (inv_all || (inv_en && inv_idx == IW'(i))) m_v[i] = 0;
      else if (fill_en && fill_idx == IW'(i)) begin
        m_v[i] = 1; m_vpn[i] = fill_vpn; m_pfn[i] = fill_pfn; m_asid[i] = fill_asid;
        m_rw[i] = fill_rw; m_d[i] = fill_dirty; m_r[i] = 0;
      end else if (e_hit && hi == i) m_r[i] = 1;
    end
    @(negedge clk);
    fill_en = 0; inv_en = 0; inv_all = 0;
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                      input logic w, input string tag);
    lk_valid = 1; lk_vpn = v; lk_asid = a; lk_write = w; lk_off = 12'h5a5;
    tick(tag);
  endtask

  task automatic fill(input int i, input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p,
                      input logic [ASID_W-1:0] a, input logic rw, input logic d);
    fill_en = 1; fill_idx = IW'(i); fill_vpn = v; fill_pfn = p; fill_asid = a;
    fill_rw = rw; fill_dirty = d;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_asid[i] = '0;
      m_rw[i] = 0; m_d[i] = 0; m_r[i] = 0;
    end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    look(20'h00001, 6'd0, 0, "R1");
    look(20'h00000, 6'd0, 1, "R1");
    fill(5, 20'h12345, 20'hABCDE, 6'd1, 1, 0);
    lk_valid = 0; tick("R10");
    look(20'h12345, 6'd1, 0, "R2");
    look(20'h12345, 6'd1, 1, "R6");
    look(20'h12345, 6'd1, 0, "R5");
    look(20'h12345, 6'd2, 0, "R3");
    fill(9, 20'h00777, 20'h00111, 6'd1, 0, 0);
    lk_valid = 0; tick("R10");
    look(20'h00777, 6'd1, 1, "R4");
    look(20'h00777, 6'd1, 1, "R5");
    look(20'h00777, 6'd1, 0, "R4");
    fill(12, 20'h00888, 20'h00222, 6'd3, 1, 1);
    fill(3, 20'h12345, 20'h0F0F0, 6'd1, 1, 1);
    look(20'h12345, 6'd1, 1, "R9");
    fill(12, 20'h00888, 20'h00222, 6'd3, 1, 1);
    look(20'h00888, 6'd3, 1, "R6");
    inv_en = 1; inv_idx = 6'd3;
    look(20'h12345, 6'd1, 0, "R9");
    look(20'h12345, 6'd1, 0, "R7");
    look(20'h00777, 6'd1, 0, "R7");
    fill(5, 20'h0BEEF, 20'h0CAFE, 6'd1, 1, 0);
    lk_valid = 0; tick("R10");
    look(20'h12345, 6'd1, 0, "R11");
    look(20'h0BEEF, 6'd1, 0, "R11");
    fill(20, 20'h04444, 20'h05555, 6'd0, 1, 0);
    inv_all = 1;
    look(20'h0BEEF, 6'd1, 0, "R8");
    look(20'h04444, 6'd0, 0, "R8");
    look(20'h0BEEF, 6'd1, 0, "R8");
    lk_valid = 0; tick("R10");
    for (int k = 0; k < 4000; k++) begin
      lk_valid = ($urandom % 8) != 0;
      lk_vpn   = VPN_W'(20'h00100 + $urandom % 8);
      lk_asid  = ASID_W'($urandom % 4);
      lk_write = 1'($urandom % 2);
      lk_off   = OFF_W'($urandom);
      if ($urandom % 3 == 0)
        fill(int'($urandom % 16), VPN_W'(20'h00100 + $urandom % 8), PFN_W'($urandom),
             ASID_W'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2));
      if ($urandom % 20 == 0) begin inv_en = 1; inv_idx = IW'($urandom % 16); end
      if ($urandom % 300 == 0) inv_all = 1;
      tick("R2");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule